// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between the command request port of a memory controller and the command bus of a single-data-rate SDRAM with four banks. Each request comes as the three active-low strobes (row strobe, column strobe, write enable), a bank select and a 12-bit address. The guard decodes the request and keeps an idle/active state for every bank. It holds the request with `req_ready` low until every spacing rule for that command is met. A legal command is then registered onto the SDRAM bus.

All spacing limits are parameters counted in clock cycles:
- activate-to-activate on the same bank (`TRC`)
- activate-to-activate across banks (`TRRD`)
- activate to read or write (`TRCD`)
- minimum active time before precharge (`TRAS`)
- maximum active time (`TRAS_MAX`)

An illegal sequence is consumed without a stall and is never forwarded. It sets a sticky error flag. A separate output reports any bank that has stayed open for too long.

Top module: `sdram_cmd_guard`

## Requirements
- R1: A request accepted in cycle t (`req_valid` and `req_ready` high) that is legal and not a NOP appears on the `sd_*` outputs in cycle t+1, with strobes, bank and address unchanged. In every other cycle the bus shows NOP: strobes `1,1,1`, bank 0, address 0.
- R2: An activate (strobes `0,1,1`) to an idle bank is stalled until at least `TRRD` cycles have passed since the last issued activate to any bank.
- R3: An activate to an idle bank is stalled until at least `TRC` cycles have passed since the last issued activate to that same bank.
- R4: A read (strobes `1,0,1`) or write (strobes `1,0,0`) to an active bank is stalled until at least `TRCD` cycles have passed since that bank was activated. Address bit 10 is forwarded but does not change bank state.
- R5: A single-bank precharge (strobes `0,1,0`, address bit 10 low) to an active bank is stalled until `TRAS` cycles have passed since its activate. A precharge-all (strobes `0,1,0`, address bit 10 high) is stalled until every active bank has met `TRAS`.
- R6: A single-bank precharge returns only the addressed bank to idle. A precharge-all returns every bank to idle, ignores the bank select, and is legal when no bank is active.
- R7: An activate to an active bank, or a read, write or single-bank precharge to an idle bank, is accepted at once. It is not forwarded, and `prot_err` rises in the next cycle and stays high until reset.
- R8: `overdue` is high in every cycle in which some bank has been active for at least `TRAS_MAX` cycles. It falls in the cycle after that bank is precharged.
- R9: A NOP request (strobes `1,1,1`) and all other strobe codes (refresh, mode load, burst stop) are accepted at once and do not change bank state. The other codes are forwarded; NOPs are not.
- R10: During and right after reset, all banks are idle, `req_ready` is high, the bus shows NOP, and `prot_err` and `overdue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ras_n | input | 1 | Requested row strobe, active low |
| req_cas_n | input | 1 | Requested column strobe, active low |
| req_we_n | input | 1 | Requested write enable, active low |
| req_ba | input | 2 | Requested bank |
| req_addr | input | 12 | Requested row/column address, bit 10 selects precharge-all |
| req_ready | output | 1 | Request is accepted at the coming edge |
| sd_ras_n | output | 1 | SDRAM row strobe |
| sd_cas_n | output | 1 | SDRAM column strobe |
| sd_we_n | output | 1 | SDRAM write enable |
| sd_ba | output | 2 | SDRAM bank |
| sd_addr | output | 12 | SDRAM address |
| prot_err | output | 1 | Sticky illegal-sequence flag |
| overdue | output | 1 | A bank has been open for the maximum time |

## Verification
The bench goes after the corners where counters can slip by one:
- **First ready cycle.** A request held under stall must go ready in exactly the cycle its window closes. A counter loaded one too high or too low shows up as `req_ready` one cycle off.
- **Precharge-all with mixed banks.** When one open bank is past `TRAS` and another is not, a design that tests only the selected bank lets the precharge through early.
- **Precharge-all with no bank open.** A design that treats this as illegal raises `prot_err` wrongly.
- **Activate to an open bank.** A design that forwards it shows the command on the bus instead of a NOP.
- **Long-open bank.** A bank held open past `TRAS_MAX` must raise `overdue` in exactly the right cycle and drop it after the precharge.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    K_NOP   = 3'd0,
    K_ACT   = 3'd1,
    K_RD    = 3'd2,
    K_WR    = 3'd3,
    K_PRE   = 3'd4,
    K_PALL  = 3'd5,
    K_OTHER = 3'd6
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic vld, input logic ras_n,
                                         input logic cas_n, input logic we_n,
                                         input logic a10);
    cmd_kind_e k;
    if (!vld) begin
      k = K_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  k = K_NOP;
        3'b011:  k = K_ACT;
        3'b101:  k = K_RD;
        3'b100:  k = K_WR;
        3'b010:  k = a10 ? K_PALL : K_PRE;
        default: k = K_OTHER;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                 vld_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic                 a10_i,
  input  logic [BA_W-1:0]      ba_i,
  output cmd_kind_e            kind_o,
  output logic [NUM_BANKS-1:0] bank_hot_o
);

  always_comb begin
    kind_o = classify(vld_i, ras_n_i, cas_n_i, we_n_i, a10_i);
  end

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_hot
      assign bank_hot_o[gb] = (ba_i == BA_W'(gb));
    end
  endgenerate

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int TRC      = 10,
  parameter int TRCD     = 3,
  parameter int TRAS     = 7,
  parameter int TRAS_MAX = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic act_i,
  input  logic pre_i,
  output logic active_o,
  output logic act_ok_o,
  output logic rw_ok_o,
  output logic pre_ok_o,
  output logic overdue_o
);

  localparam int RC_W  = $clog2(TRC + 1);
  localparam int RCD_W = $clog2(TRCD + 1);
  localparam int RAS_W = $clog2(TRAS + 1);
  localparam int AGE_W = $clog2(TRAS_MAX + 1);

  logic             active_q;
  logic [RC_W-1:0]  rc_q;
  logic [RCD_W-1:0] rcd_q;
  logic [RAS_W-1:0] ras_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rc_q     <= '0;
      rcd_q    <= '0;
      ras_q    <= '0;
      age_q    <= '0;
    end else if (act_i) begin
      active_q <= 1'b1;
      rc_q     <= RC_W'(TRC - 1);
      rcd_q    <= RCD_W'(TRCD - 1);
      ras_q    <= RAS_W'(TRAS - 1);
      age_q    <= AGE_W'(1);
    end else begin
      if (rc_q != '0)  rc_q  <= rc_q - 1'b1;
      if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (pre_i) begin
        active_q <= 1'b0;
        age_q    <= '0;
      end else if (active_q && age_q != AGE_W'(TRAS_MAX)) begin
        age_q <= age_q + 1'b1;
      end
    end
  end

  assign active_o  = active_q;
  assign act_ok_o  = (rc_q == '0);
  assign rw_ok_o   = (rcd_q == '0);
  assign pre_ok_o  = (ras_q == '0);
  assign overdue_o = active_q && (age_q == AGE_W'(TRAS_MAX));

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int TRC       = 10,
  parameter int TRRD      = 2,
  parameter int TRCD      = 3,
  parameter int TRAS      = 7,
  parameter int TRAS_MAX  = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_ras_n,
  input  logic                       req_cas_n,
  input  logic                       req_we_n,
  input  logic [$clog2(NUM_BANKS)-1:0] req_ba,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic                       req_ready,
  output logic                       sd_ras_n,
  output logic                       sd_cas_n,
  output logic                       sd_we_n,
  output logic [$clog2(NUM_BANKS)-1:0] sd_ba,
  output logic [ADDR_W-1:0]          sd_addr,
  output logic                       prot_err,
  output logic                       overdue
);

  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int RRD_W = $clog2(TRRD + 1);

  cmd_kind_e            kind;
  logic [NUM_BANKS-1:0] bank_hot;
  logic [NUM_BANKS-1:0] b_active, b_act_ok, b_rw_ok, b_pre_ok, b_overdue;
  logic [NUM_BANKS-1:0] act_hit, pre_hit;
  logic [RRD_W-1:0]     rrd_q;
  logic                 rrd_ok, sel_active, timing_ok, illegal, fire, issue;

  sdram_cmd_decode #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W)
  ) u_dec (
    .vld_i     (req_valid),
    .ras_n_i   (req_ras_n),
    .cas_n_i   (req_cas_n),
    .we_n_i    (req_we_n),
    .a10_i     (req_addr[10]),
    .ba_i      (req_ba),
    .kind_o    (kind),
    .bank_hot_o(bank_hot)
  );

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign act_hit[gb] = issue && (kind == K_ACT) && bank_hot[gb];
      assign pre_hit[gb] = issue && ((kind == K_PALL) ||
                                     ((kind == K_PRE) && bank_hot[gb]));
      sdram_bank_timer #(
        .TRC     (TRC),
        .TRCD    (TRCD),
        .TRAS    (TRAS),
        .TRAS_MAX(TRAS_MAX)
      ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .act_i    (act_hit[gb]),
        .pre_i    (pre_hit[gb]),
        .active_o (b_active[gb]),
        .act_ok_o (b_act_ok[gb]),
        .rw_ok_o  (b_rw_ok[gb]),
        .pre_ok_o (b_pre_ok[gb]),
        .overdue_o(b_overdue[gb])
      );
    end
  endgenerate

  assign rrd_ok     = (rrd_q == '0);
  assign sel_active = b_active[req_ba];

  always_comb begin
    timing_ok = 1'b1;
    illegal   = 1'b0;
    unique case (kind)
      K_ACT: begin
        illegal   = sel_active;
        timing_ok = sel_active | (b_act_ok[req_ba] & rrd_ok);
      end
      K_RD, K_WR: begin
        illegal   = !sel_active;
        timing_ok = !sel_active | b_rw_ok[req_ba];
      end
      K_PRE: begin
        illegal   = !sel_active;
        timing_ok = !sel_active | b_pre_ok[req_ba];
      end
      K_PALL: begin
        timing_ok = &(~b_active | b_pre_ok);
      end
      default: begin
        timing_ok = 1'b1;
      end
    endcase
  end

  assign req_ready = timing_ok;
  assign fire      = req_valid && timing_ok;
  assign issue     = fire && !illegal && (kind != K_NOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_q <= '0;
    end else if (|act_hit) begin
      rrd_q <= RRD_W'(TRRD - 1);
    end else if (rrd_q != '0) begin
      rrd_q <= rrd_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_ras_n <= 1'b1;
      sd_cas_n <= 1'b1;
      sd_we_n  <= 1'b1;
      sd_ba    <= '0;
      sd_addr  <= '0;
      prot_err <= 1'b0;
    end else begin
      if (issue) begin
        sd_ras_n <= req_ras_n;
        sd_cas_n <= req_cas_n;
        sd_we_n  <= req_we_n;
        sd_ba    <= req_ba;
        sd_addr  <= req_addr;
      end else begin
        sd_ras_n <= 1'b1;
        sd_cas_n <= 1'b1;
        sd_we_n  <= 1'b1;
        sd_ba    <= '0;
        sd_addr  <= '0;
      end
      if (fire && illegal) prot_err <= 1'b1;
    end
  end

  assign overdue = |b_overdue;

endmodule

// File: rtl/sdram_cmd_guard_checker.sv
module sdram_cmd_guard_checker #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int TRC       = 10,
  parameter int TRRD      = 2,
  parameter int TRCD      = 3,
  parameter int TRAS      = 7,
  parameter int TRAS_MAX  = 64
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic                         req_ras_n,
  input logic                         req_cas_n,
  input logic                         req_we_n,
  input logic [$clog2(NUM_BANKS)-1:0] req_ba,
  input logic [ADDR_W-1:0]            req_addr,
  input logic                         req_ready,
  input logic                         sd_ras_n,
  input logic                         sd_cas_n,
  input logic                         sd_we_n,
  input logic [$clog2(NUM_BANKS)-1:0] sd_ba,
  input logic [ADDR_W-1:0]            sd_addr,
  input logic                         prot_err,
  input logic                         overdue
);

  localparam int BA_W = $clog2(NUM_BANKS);
  localparam int CW   = $clog2(TRC + TRAS + TRCD + TRRD + 2);

  logic          bus_act, bus_rw, bus_pre;
  logic [CW-1:0] gap_any;

  assign bus_act = !sd_ras_n &&  sd_cas_n &&  sd_we_n;
  assign bus_rw  =  sd_ras_n && !sd_cas_n;
  assign bus_pre = !sd_ras_n &&  sd_cas_n && !sd_we_n;

  always_ff @(posedge clk) begin
    if (rst)                  gap_any <= '1;
    else if (bus_act)         gap_any <= CW'(1);
    else if (gap_any != '1)   gap_any <= gap_any + 1'b1;
  end

  a_r2_rrd_spacing: assert property (@(posedge clk) disable iff (rst)
    bus_act |-> (gap_any >= CW'(TRRD)));

  a_r1_idle_bus_nop: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (sd_ras_n && sd_cas_n && sd_we_n));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    prot_err |=> prot_err);

  a_r9_nop_passes: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ras_n && req_cas_n && req_we_n) |-> req_ready);

  a_r10_reset_clean: assert property (@(posedge clk)
    rst |=> (!prot_err && !overdue && sd_ras_n && sd_cas_n && sd_we_n));

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_chk
      logic [CW-1:0] since;
      logic          hit;
      assign hit = (sd_ba == BA_W'(gb));
      always_ff @(posedge clk) begin
        if (rst)                   since <= '1;
        else if (bus_act && hit)   since <= CW'(1);
        else if (since != '1)      since <= since + 1'b1;
      end

      a_r3_rc_spacing: assert property (@(posedge clk) disable iff (rst)
        (bus_act && hit) |-> (since >= CW'(TRC)));

      a_r4_rcd_spacing: assert property (@(posedge clk) disable iff (rst)
        (bus_rw && hit) |-> (since >= CW'(TRCD)));

      a_r5_ras_min: assert property (@(posedge clk) disable iff (rst)
        (bus_pre && (hit || sd_addr[10])) |-> (since >= CW'(TRAS)));
    end
  endgenerate

endmodule

bind sdram_cmd_guard sdram_cmd_guard_checker #(
  .NUM_BANKS(NUM_BANKS),
  .ADDR_W   (ADDR_W),
  .TRC      (TRC),
  .TRRD     (TRRD),
  .TRCD     (TRCD),
  .TRAS     (TRAS),
  .TRAS_MAX (TRAS_MAX)
) u_guard_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ras_n(req_ras_n),
  .req_cas_n(req_cas_n),
  .req_we_n (req_we_n),
  .req_ba   (req_ba),
  .req_addr (req_addr),
  .req_ready(req_ready),
  .sd_ras_n (sd_ras_n),
  .sd_cas_n (sd_cas_n),
  .sd_we_n  (sd_we_n),
  .sd_ba    (sd_ba),
  .sd_addr  (sd_addr),
  .prot_err (prot_err),
  .overdue  (overdue)
);

// File: tb/sdram_cmd_guard_bench.sv
module sdram_cmd_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int AW   = 12;
  localparam int TRC  = 10;
  localparam int TRRD = 2;
  localparam int TRCD = 3;
  localparam int TRAS = 7;
  localparam int TMAX = 64;

  localparam int KN = 0, KA = 1, KR = 2, KW = 3, KP = 4, KPA = 5, KO = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ras_n = 1'b1, req_cas_n = 1'b1, req_we_n = 1'b1;
  logic [1:0]    req_ba = '0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, sd_ras_n, sd_cas_n, sd_we_n, prot_err, overdue;
  logic [1:0]    sd_ba;
  logic [AW-1:0] sd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_guard #(
    .NUM_BANKS(NB), .ADDR_W(AW), .TRC(TRC), .TRRD(TRRD),
    .TRCD(TRCD), .TRAS(TRAS), .TRAS_MAX(TMAX)
  ) u_sdram_cmd_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ras_n(req_ras_n),
    .req_cas_n(req_cas_n), .req_we_n(req_we_n), .req_ba(req_ba),
    .req_addr(req_addr), .req_ready(req_ready), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .prot_err(prot_err), .overdue(overdue)
  );

  int  n_chk = 0, n_bad = 0;
  int  cyc;
  int  last_act [NB];
  int  last_any;
  bit  open_m [NB];
  bit  err_m;
  logic [2:0]    eb_cmd;
  logic [1:0]    eb_ba;
  logic [AW-1:0] eb_addr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int kind_of(bit v, bit r, bit c, bit w, bit a10);
    if (!v) return KN;
    case ({r, c, w})
      3'b111: return KN;
      3'b011: return KA;
      3'b101: return KR;
      3'b100: return KW;
      3'b010: return a10 ? KPA : KP;
      default: return KO;
    endcase
  endfunction

  function automatic bit is_illegal(int k, int b);
    if (k == KA) return open_m[b];
    if (k == KR || k == KW || k == KP) return !open_m[b];
    return 1'b0;
  endfunction

  function automatic bit exp_ready(int k, int b);
    if (k == KA)
      return open_m[b] || ((cyc - last_act[b] >= TRC) && (cyc - last_any >= TRRD));
    if (k == KR || k == KW) return !open_m[b] || (cyc - last_act[b] >= TRCD);
    if (k == KP) return !open_m[b] || (cyc - last_act[b] >= TRAS);
    if (k == KPA) begin
      for (int i = 0; i < NB; i++)
        if (open_m[i] && (cyc - last_act[i] < TRAS)) return 1'b0;
      return 1'b1;
    end
    return 1'b1;
  endfunction

  function automatic bit exp_overdue();
    for (int i = 0; i < NB; i++)
      if (open_m[i] && (cyc - last_act[i] >= TMAX)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    cyc = 0;
    last_any = -1000;
    err_m = 1'b0;
    eb_cmd = 3'b111; eb_ba = '0; eb_addr = '0;
    for (int i = 0; i < NB; i++) begin
      last_act[i] = -1000;
      open_m[i] = 1'b0;
    end
  endtask

  // One cycle: check registered outputs, present request, check ready, advance model.
  task automatic step(input bit v, input logic [2:0] cmd, input logic [1:0] b,
                      input logic [AW-1:0] a, output bit taken);
    int  k;
    bit  rdy, bad;
    chk({sd_ras_n, sd_cas_n, sd_we_n} == eb_cmd, "R1", "bus strobes",
        {sd_ras_n, sd_cas_n, sd_we_n}, eb_cmd);
    chk(sd_ba == eb_ba && sd_addr == eb_addr, "R1", "bus bank/addr",
        {sd_ba, sd_addr}, {eb_ba, eb_addr});
    chk(prot_err == err_m, "R7", "prot_err", prot_err, err_m);
    chk(overdue == exp_overdue(), "R8", "overdue", overdue, exp_overdue());
    req_valid = v;
    {req_ras_n, req_cas_n, req_we_n} = cmd;
    req_ba = b;
    req_addr = a;
    #1;
    k   = kind_of(v, cmd[2], cmd[1], cmd[0], a[10]);
    rdy = exp_ready(k, b);
    if (k == KA)                chk(req_ready == rdy, "R2", "ready on activate", req_ready, rdy);
    else if (k == KR || k == KW) chk(req_ready == rdy, "R4", "ready on read/write", req_ready, rdy);
    else if (k == KP || k == KPA) chk(req_ready == rdy, "R5", "ready on precharge", req_ready, rdy);
    else                        chk(req_ready == rdy, "R9", "ready on nop/other", req_ready, rdy);
    taken = v && rdy;
    bad = is_illegal(k, b);
    eb_cmd = 3'b111; eb_ba = '0; eb_addr = '0;
    if (taken && bad) err_m = 1'b1;
    if (taken && !bad && k != KN) begin
      eb_cmd = cmd; eb_ba = b; eb_addr = a;
      if (k == KA) begin
        open_m[b] = 1'b1; last_act[b] = cyc; last_any = cyc;
      end else if (k == KP) begin
        open_m[b] = 1'b0;
      end else if (k == KPA) begin
        for (int i = 0; i < NB; i++) open_m[i] = 1'b0;
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic hold(input logic [2:0] cmd, input logic [1:0] b,
                      input logic [AW-1:0] a, output int waited);
    bit t;
    waited = 0;
    t = 1'b0;
    while (!t && waited < 60) begin
      step(1'b1, cmd, b, a, t);
      if (!t) waited++;
    end
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(1'b0, 3'b111, 2'd0, '0, t);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    chk(prot_err == 1'b0 && overdue == 1'b0, "R10", "flags after reset",
        {prot_err, overdue}, 0);
    chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R10", "bus after reset",
        {sd_ras_n, sd_cas_n, sd_we_n}, 7);
  endtask

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_NOP = 3'b111;

  bit finished = 1'b0;

  initial begin
    int  w;
    bit  t;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();

    // Directed: cross-bank and same-bank spacing, first ready cycle
    hold(C_ACT, 2'd0, 12'h123, w);
    hold(C_ACT, 2'd1, 12'h045, w);
    chk(w == TRRD - 1, "R2", "cycles stalled for second bank", w, TRRD - 1);
    hold(C_RD, 2'd0, 12'h010, w);
    chk(w == 0, "R4", "read after tRCD already met", w, 0);
    hold(C_WR, 2'd1, 12'h011, w);
    hold(C_PRE, 2'd2, 12'h000, w);          // idle bank: illegal, no stall
    chk(w == 0, "R7", "illegal precharge not stalled", w, 0);
    step(1'b0, C_NOP, 2'd0, '0, t);
    chk(prot_err == 1'b1, "R7", "error after precharge to idle bank", prot_err, 1);
    do_reset();

    hold(C_ACT, 2'd3, 12'h7FF, w);
    hold(C_ACT, 2'd0, 12'h001, w);
    hold(C_PRE, 2'd3, 12'h000, w);          // single bank precharge
    hold(C_ACT, 2'd3, 12'h002, w);          // waits for tRC of bank 3
    chk(open_m[0] == 1'b1, "R6", "bank 0 left open by single precharge", open_m[0], 1);
    hold(C_RD, 2'd0, 12'h000, w);           // still legal: bank 0 open
    chk(prot_err == 1'b0, "R6", "no error reading other bank", prot_err, 0);
    hold(C_PRE, 2'd1, 12'h400, w);          // precharge-all, bank select ignored
    hold(C_PRE, 2'd0, 12'h400, w);          // precharge-all with nothing open
    chk(w == 0, "R6", "precharge-all with no open bank", w, 0);
    hold(C_REF, 2'd0, 12'h000, w);
    chk(w == 0, "R9", "refresh passes", w, 0);
    idle(2);
    chk(prot_err == 1'b0, "R6", "no error after legal sequence", prot_err, 0);

    // Directed: activate to an open bank is dropped
    hold(C_ACT, 2'd2, 12'h0AA, w);
    idle(TRC);
    hold(C_ACT, 2'd2, 12'h0BB, w);
    idle(1);
    chk(prot_err == 1'b1, "R7", "second activate flagged", prot_err, 1);

    // Directed: long open bank raises overdue, precharge clears it
    do_reset();
    hold(C_ACT, 2'd1, 12'h100, w);
    idle(TMAX + 3);
    chk(overdue == 1'b1, "R8", "overdue after max time", overdue, 1);
    hold(C_PRE, 2'd1, 12'h000, w);
    idle(1);
    chk(overdue == 1'b0, "R8", "overdue cleared", overdue, 0);
    do_reset();

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] c;
      r = $urandom_range(0, 99);
      if (r < 22)      c = C_ACT;
      else if (r < 34) c = C_RD;
      else if (r < 44) c = C_WR;
      else if (r < 56) c = C_PRE;
      else if (r < 60) c = C_REF;
      else             c = C_NOP;
      step($urandom_range(0, 9) != 0, c, 2'($urandom_range(0, 3)),
           AW'($urandom_range(0, 4095)), t);
      if (n % 1000 == 999) do_reset();
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule